// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets the cores of a small multicore cluster interrupt one another. Every core reaches it through one shared command port. A command carries an operation code, the identity of the issuing core and a parameter that names a second core. With these commands a core can do four things:

- Raise an interrupt at a target core.
- Ask whether an interrupt it raised earlier is still unacknowledged.
- Read which cores currently have interrupts pending at itself.
- Acknowledge the interrupt from one named sender.

The block keeps one pending flag for every ordered (sender, target) pair. Each core has one interrupt line, which is the OR of every flag aimed at that core. When several senders signal the same target at once, the target sees only one asserted line. The target then reads a multi-bit sender mask and acknowledges the senders one at a time. Arbitration among cores sits outside the block, so at most one command arrives per cycle.

Top module: `ipi_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every pair flag, drives every interrupt line low and sets the readback register to zero.
- R2: A raise command (opcode 2) from core `i` with `cmd_param` = `t` sets the (i, t) pair flag, and `irq[t]` is high from the clock edge that accepts the command.
- R3: A status command (opcode 1) from core `i` with `cmd_param` = `t` loads the readback register, at the accepting edge, with 1 if pair (i, t) is still pending and 0 otherwise.
- R4: A source command (opcode 3) from core `i` loads the readback register with a mask in which bit `s` is set exactly when pair (s, i) is pending. Bits at and above the core count are zero.
- R5: When several senders have flags pending at one target, that target's single line stays high and the source mask shows every such sender.
- R6: An acknowledge command (opcode 4) from core `i` with `cmd_param` = `s` clears only pair (s, i). The line `irq[i]` stays high while any other sender is still pending at `i`, and drops once none is.
- R7: Raising a pair that is already pending leaves it pending without queuing a second event, so a single acknowledge clears it.
- R8: Opcode 0, opcodes 5 to 7, and any cycle with `cmd_valid` low change no flag and no line. The readback register changes only on status and source commands.
- R9: A command whose `cmd_param` is not below the core count is ignored entirely: no flag changes and the readback register holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_core | input | ID_W (2) | Index of the issuing core |
| cmd_param | input | PARAM_W (4) | Target or sender core index |
| rd_data | output | RB_W (32) | Readback register |
| irq | output | N (4) | One interrupt line per core |

## Verification
The bench first builds up three concurrent senders at one target. It then acknowledges them one by one and checks that the line stays high until the last acknowledge. A design that kept a single flag per target would drop the line too early, or would lose the senders it never reported.

A second raise of an already-pending pair must be cleared by one acknowledge. A counting design would leave the line stuck high.

The bench also probes:
- that an acknowledge clears the (sender, issuer) pair and not the transposed one;
- out-of-range indices, which a design truncating the parameter would map onto a real core;
- reserved opcodes, which must leave the readback register untouched.

A long pseudo-random command stream is compared against the behavioural model every cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PEEK  = 3'd1,
        OP_RAISE = 3'd2,
        OP_WHO   = 3'd3,
        OP_ACK   = 3'd4
    } ipi_op_e;

    typedef struct packed {
        logic peek;
        logic raise;
        logic who;
        logic ack;
    } ipi_act_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_pkg::*;
#(
    parameter int N       = 4,
    parameter int ID_W    = 2,
    parameter int PARAM_W = 4
) (
    input  logic               valid,
    input  logic [2:0]         op,
    input  logic [ID_W-1:0]    core_id,
    input  logic [PARAM_W-1:0] param,
    output ipi_act_t           act,
    output logic [N-1:0]       issuer_oh,
    output logic [N-1:0]       peer_oh
);

    logic peer_ok;

    always_comb begin
        peer_ok   = (int'(param) < N);
        issuer_oh = N'(1) << core_id;
        peer_oh   = N'(1) << param;
        act       = '0;
        if (valid && peer_ok) begin
            case (op)
                OP_PEEK:  act.peek  = 1'b1;
                OP_RAISE: act.raise = 1'b1;
                OP_WHO:   act.who   = 1'b1;
                OP_ACK:   act.ack   = 1'b1;
                default:  act       = '0;
            endcase
        end
    end

    // Only one action can be decoded from a single command.
    always_comb begin
        AST_ONE_ACTION: assert ($onehot0(act)); // R8
    end

endmodule

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           do_raise,
    input  logic           do_ack,
    input  logic [N-1:0]   issuer_oh,
    input  logic [N-1:0]   peer_oh,
    output logic [N*N-1:0] pend,
    output logic [N-1:0]   irq
);

    localparam int PAIRS = N * N;

    typedef struct packed {
        logic [PAIRS-1:0] pend;
        logic [N-1:0]     irq;
    } mat_t;

    mat_t st_d, st_q;

    // Flag index is sender*N + target.
    always_comb begin
        st_d = st_q;
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                if (do_raise && issuer_oh[s] && peer_oh[t])
                    st_d.pend[s*N+t] = 1'b1;
                if (do_ack && peer_oh[s] && issuer_oh[t])
                    st_d.pend[s*N+t] = 1'b0;
            end
        end
        for (int t = 0; t < N; t++) begin
            st_d.irq[t] = 1'b0;
            for (int s = 0; s < N; s++)
                st_d.irq[t] = st_d.irq[t] | st_d.pend[s*N+t];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign irq  = st_q.irq;

    for (genvar gs = 0; gs < N; gs++) begin : g_snd
        for (genvar gt = 0; gt < N; gt++) begin : g_tgt
            AST_RAISE_SETS: assert property (@(posedge clk) disable iff (rst)
                (do_raise && issuer_oh[gs] && peer_oh[gt]) |=> pend[gs*N+gt]); // R2
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (do_ack && peer_oh[gs] && issuer_oh[gt]) |=> !pend[gs*N+gt]); // R6
            AST_PEND_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (pend[gs*N+gt] && !(do_ack && peer_oh[gs] && issuer_oh[gt]))
                |=> pend[gs*N+gt]); // R7
        end
    end

    for (genvar gt = 0; gt < N; gt++) begin : g_line
        AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
            (do_raise && peer_oh[gt]) |=> irq[gt]); // R5
        AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (irq[gt] && !(do_ack && issuer_oh[gt])) |=> irq[gt]); // R6
    end

endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
    parameter int N    = 4,
    parameter int RB_W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           do_peek,
    input  logic           do_who,
    input  logic [N-1:0]   issuer_oh,
    input  logic [N-1:0]   peer_oh,
    input  logic [N*N-1:0] pend,
    output logic [RB_W-1:0] rb
);

    typedef struct packed {
        logic [RB_W-1:0] rb;
    } rb_t;

    rb_t st_d, st_q;
    logic hit;
    logic [N-1:0] senders;

    always_comb begin
        hit     = 1'b0;
        senders = '0;
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                hit        = hit | (pend[s*N+t] & issuer_oh[s] & peer_oh[t]);
                senders[s] = senders[s] | (pend[s*N+t] & issuer_oh[t]);
            end
        end
        st_d = st_q;
        if (do_peek)
            st_d.rb = RB_W'(hit);
        else if (do_who)
            st_d.rb = RB_W'(senders);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rb = st_q.rb;

    AST_RB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(do_peek || do_who) |=> $stable(rb)); // R8
    AST_PEEK_BINARY: assert property (@(posedge clk) disable iff (rst)
        do_peek |=> (rb[RB_W-1:1] == '0)); // R3
    AST_WHO_UPPER: assert property (@(posedge clk) disable iff (rst)
        do_who |=> ((rb >> N) == '0)); // R4

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter  int N       = 4,
    parameter  int PARAM_W = 4,
    parameter  int RB_W    = 32,
    localparam int ID_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [ID_W-1:0]    cmd_core,
    input  logic [PARAM_W-1:0] cmd_param,
    output logic [RB_W-1:0]    rd_data,
    output logic [N-1:0]       irq
);

    ipi_act_t       act;
    logic [N-1:0]   issuer_oh;
    logic [N-1:0]   peer_oh;
    logic [N*N-1:0] pend;

    ipi_cmd_decode #(.N(N), .ID_W(ID_W), .PARAM_W(PARAM_W)) u_dec (
        .valid     (cmd_valid),
        .op        (cmd_op),
        .core_id   (cmd_core),
        .param     (cmd_param),
        .act       (act),
        .issuer_oh (issuer_oh),
        .peer_oh   (peer_oh)
    );

    ipi_pend_matrix #(.N(N)) u_mat (
        .clk       (clk),
        .rst       (rst),
        .do_raise  (act.raise),
        .do_ack    (act.ack),
        .issuer_oh (issuer_oh),
        .peer_oh   (peer_oh),
        .pend      (pend),
        .irq       (irq)
    );

    ipi_readback #(.N(N), .RB_W(RB_W)) u_rb (
        .clk       (clk),
        .rst       (rst),
        .do_peek   (act.peek),
        .do_who    (act.who),
        .issuer_oh (issuer_oh),
        .peer_oh   (peer_oh),
        .pend      (pend),
        .rb        (rd_data)
    );

    AST_BAD_PEER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && int'(cmd_param) >= N) |=> ($stable(rd_data) && $stable(pend))); // R9

endmodule

// File: tb/ipi_ctrl_test.sv
module ipi_ctrl_test;

    localparam int N      = 4;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_core;
    logic [3:0]  cmd_param;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Behavioural reference: mp[sender][target]
    bit          mp [N][N];
    int unsigned mrb;

    always #(CLK_NS/2) clk = ~clk;

    ipi_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_core  (cmd_core),
        .cmd_param (cmd_param),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic model(input bit v, input int op, input int id, input int p);
        int unsigned m;
        if (!v || p >= N) return;
        case (op)
            1: mrb = mp[id][p] ? 1 : 0;
            2: mp[id][p] = 1;
            3: begin
                m = 0;
                for (int s = 0; s < N; s++) if (mp[s][id]) m |= (1 << s);
                mrb = m;
            end
            4: mp[p][id] = 0;
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        logic [3:0] ei;
        for (int t = 0; t < N; t++) begin
            ei[t] = 0;
            for (int s = 0; s < N; s++) ei[t] |= mp[s][t];
        end
        checks++;
        if (irq !== ei) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, ei);
        end
        checks++;
        if (rd_data !== 32'(mrb)) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, mrb);
        end
    endtask

    task automatic issue(input bit v, input int op, input int id, input int p, input string req);
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_core  = 2'(id);
        cmd_param = 4'(p);
        @(posedge clk);
        model(v, op, id, p);
        @(negedge clk);
        cmd_valid = 0;
        compare(req);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < N; s++) for (int t = 0; t < N; t++) mp[s][t] = 0;
        mrb = 0;
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_core = 0; cmd_param = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R1");

        issue(1, 2, 0, 2, "R2");          // 0 -> 2
        issue(1, 1, 0, 2, "R3");          // pending: 1
        issue(1, 1, 1, 2, "R3");          // not pending: 0
        issue(1, 2, 1, 2, "R5");          // 1 -> 2
        issue(1, 2, 3, 2, "R5");          // 3 -> 2
        issue(1, 3, 2, 0, "R4");          // mask 0xB
        issue(1, 3, 0, 0, "R4");          // nothing at core 0
        issue(1, 4, 2, 1, "R6");          // ack sender 1, line stays
        issue(1, 3, 2, 0, "R6");          // mask 0x9
        issue(1, 4, 1, 2, "R6");          // transposed ack: no effect
        issue(1, 4, 2, 0, "R6");
        issue(1, 4, 2, 3, "R6");          // line drops
        issue(1, 2, 0, 1, "R7");
        issue(1, 2, 0, 1, "R7");          // raise again, no queue
        issue(1, 4, 1, 0, "R7");          // one ack clears
        issue(1, 1, 0, 1, "R7");
        issue(1, 2, 3, 3, "R2");          // self interrupt
        issue(1, 3, 3, 0, "R4");
        issue(0, 2, 1, 0, "R8");          // valid low
        issue(1, 0, 1, 0, "R8");
        for (int op = 5; op < 8; op++) issue(1, op, 1, 0, "R8");
        issue(1, 2, 1, 0, "R8");
        issue(1, 4, 0, 1, "R8");          // rb holds after ack
        for (int p = 4; p < 16; p++) issue(1, 2, 2, p, "R9");
        issue(1, 1, 3, 9, "R9");          // rb holds
        issue(1, 3, 0, 12, "R9");

        lf = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[15:13] != 0, int'(lf[2:0]) % 5, int'(lf[4:3]),
                  lf[12] ? int'(lf[8:5]) : int'(lf[6:5]), "R5");
        end

        rst = 1;
        @(posedge clk);
        for (int s = 0; s < N; s++) for (int t = 0; t < N; t++) mp[s][t] = 0;
        mrb = 0;
        @(negedge clk);
        rst = 0;
        compare("R1");
        summary();
    end

endmodule